// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request interface and an external static RAM that has no clock. The RAM has 19 address bits, 8 data bits, three active-low strobes (select, output enable, write enable) and one bidirectional data bus. The user side offers one beat at a time through a valid/ready handshake: an address, a direction flag and, for stores, a data byte. Loads return one byte with a single-cycle valid strobe.

Each analog timing limit of the RAM becomes a parameter counted in clock cycles. These limits cover the power-up delay, the read cycle, the write pulse, data setup and hold around the rising write enable, the bus release time after a read, and the turnaround after a write. The defaults assume a 12 ns part and a 100 MHz clock, with every value rounded up. All strobes, the address and the bus drive enable come straight from flip-flops, so the pins do not glitch.

A store first raises output enable and waits for the RAM to let go of the bus. It then lowers write enable and drives the byte. It raises write enable while the byte is still driven, and only then releases the bus and deselects the RAM. A load holds select and output enable low for the whole read cycle and registers the bus on the last cycle of that cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied, mem_ce_n, mem_oe_n and mem_we_n are 1, rsp_valid is 0 and req_ready is 0.
- R2: After reset is released, req_ready reads 0 through the BOOT_CYC-th rising edge and first reads 1 after rising edge BOOT_CYC+1.
- R3: The controller drives mem_dq only while mem_ce_n is 0 and mem_oe_n is 1 during a store. While a load holds mem_ce_n and mem_oe_n at 0, the bus carries the RAM's data unaltered.
- R4: Before write enable falls, a store holds mem_ce_n low with mem_we_n and mem_oe_n high for exactly WHZ_CYC cycles. Write enable then stays low for exactly PULSE_CYC cycles, where PULSE_CYC = max(WE_CYC, SETUP_CYC, WC_CYC-WHZ_CYC-HOLD_CYC). The store byte is still on mem_dq in the first cycle after write enable rises.
- R5: mem_oe_n is 1 and mem_ce_n is 0 in every cycle in which mem_we_n is 0, and mem_addr does not change in the cycle after any cycle with mem_we_n at 0.
- R6: A load holds mem_ce_n and mem_oe_n at 0, with mem_we_n at 1, for exactly RD_CYC cycles. rsp_valid is then 1 for exactly one cycle, with rsp_rdata holding the byte sampled on the last of those cycles.
- R7: After a store's write enable rises, mem_ce_n stays 1 for at least TURN_CYC+1 cycles before the next access selects the RAM.
- R8: A request is taken only at a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the access and any turnaround are complete.
- R9: A load returns the byte most recently stored at that address. A load of an address never stored returns the RAM's existing content.
- R10: While req_valid is 0, no access starts: mem_ce_n stays 1 and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | One-cycle strobe: load data valid |
| rsp_rdata | output | 8 | Load data |
| mem_addr | output | 19 | RAM address pins |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq | inout | 8 | RAM data bus |

## Verification
A wrong phase or a mis-loaded phase counter shows up at once on the strobe pins. One cycle too many or too few of low write enable, low output enable or high select is caught by the run-length monitor as soon as that strobe returns high. A store that ends early, or whose data is released too soon, writes a wrong byte into the RAM model. That fault surfaces later, on the next load of that address, as a scoreboard mismatch. Any overlap between the bus drive and a read window either trips an in-design assertion in the same cycle or corrupts the load byte.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_BOOT,
      PH_IDLE,
      PH_READ,
      PH_WR_SETUP,
      PH_WR_PULSE,
      PH_WR_HOLD,
      PH_TURN
   } phase_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_boot_timer.sv
module sram_boot_timer #(
   parameter int unsigned BOOT_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   generate
      if (BOOT_CYC == 0) begin : g_none
         assign done = 1'b1;
      end else begin : g_count
         localparam int unsigned CW = $clog2(BOOT_CYC + 1);
         logic [CW-1:0] cnt;
         logic          done_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               done_q <= 1'b0;
            end else if (!done_q) begin
               cnt    <= cnt + 1'b1;
               done_q <= (cnt == CW'(BOOT_CYC - 1));
            end
         end

         assign done = done_q;

         AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            done_q |=> done_q); // R2
      end
   endgenerate
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned RD_CYC    = 2,
   parameter int unsigned WHZ_CYC   = 1,
   parameter int unsigned PULSE_CYC = 1,
   parameter int unsigned HOLD_CYC  = 1,
   parameter int unsigned TURN_CYC  = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_done,
   input  logic req_fire,
   input  logic req_we,
   output logic ready,
   output logic ce_n,
   output logic oe_n,
   output logic we_n,
   output logic drive,
   output logic capture
);
   localparam int unsigned LMAX = max3(max3(RD_CYC, WHZ_CYC, PULSE_CYC),
                                       HOLD_CYC, TURN_CYC);
   localparam int unsigned CW   = (LMAX < 2) ? 1 : $clog2(LMAX);

   phase_t        phase, nxt;
   logic [CW-1:0] cnt;
   logic          last;
   int unsigned   nxt_len;

   assign last = (cnt == '0);

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_BOOT:     if (boot_done) nxt = PH_IDLE;
         PH_IDLE:     if (req_fire)  nxt = req_we ? PH_WR_SETUP : PH_READ;
         PH_READ:     if (last)      nxt = PH_IDLE;
         PH_WR_SETUP: if (last)      nxt = PH_WR_PULSE;
         PH_WR_PULSE: if (last)      nxt = PH_WR_HOLD;
         PH_WR_HOLD:  if (last)      nxt = PH_TURN;
         PH_TURN:     if (last)      nxt = PH_IDLE;
         default:                    nxt = PH_BOOT;
      endcase
   end

   always_comb begin
      unique case (nxt)
         PH_READ:     nxt_len = RD_CYC;
         PH_WR_SETUP: nxt_len = WHZ_CYC;
         PH_WR_PULSE: nxt_len = PULSE_CYC;
         PH_WR_HOLD:  nxt_len = HOLD_CYC;
         PH_TURN:     nxt_len = TURN_CYC;
         default:     nxt_len = 1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_BOOT;
         cnt   <= '0;
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         drive <= 1'b0;
      end else begin
         phase <= nxt;
         if (nxt != phase) cnt <= CW'(nxt_len - 1);
         else if (!last)   cnt <= cnt - 1'b1;
         ce_n  <= !(nxt inside {PH_READ, PH_WR_SETUP, PH_WR_PULSE, PH_WR_HOLD});
         oe_n  <= (nxt != PH_READ);
         we_n  <= (nxt != PH_WR_PULSE);
         drive <= (nxt inside {PH_WR_PULSE, PH_WR_HOLD});
      end
   end

   assign ready   = (phase == PH_IDLE);
   assign capture = (phase == PH_READ) && last;

   AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (oe_n && !ce_n)); // R5
   AST_BOOT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_done |-> !ready); // R2
   AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (!oe_n && !ce_n && we_n)); // R6
   AST_TURN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TURN) |-> (ce_n && !drive)); // R7
   AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> !ready); // R8
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned AW        = 19,
   parameter int unsigned DW        = 8,
   parameter int unsigned BOOT_CYC  = 100000,
   parameter int unsigned RD_CYC    = 2,
   parameter int unsigned WE_CYC    = 1,
   parameter int unsigned SETUP_CYC = 1,
   parameter int unsigned HOLD_CYC  = 1,
   parameter int unsigned WHZ_CYC   = 1,
   parameter int unsigned TURN_CYC  = 1,
   parameter int unsigned WC_CYC    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   inout  wire  [DW-1:0] mem_dq
);
   localparam int unsigned WC_REST   = (WC_CYC > WHZ_CYC + HOLD_CYC) ?
                                       (WC_CYC - WHZ_CYC - HOLD_CYC) : 1;
   localparam int unsigned PULSE_CYC = max3(WE_CYC, SETUP_CYC, WC_REST);

   generate
      if (AW < 1 || DW < 1)  begin : g_bad_w $error("AW and DW must be nonzero"); end
      if (RD_CYC < 1)        begin : g_bad_r $error("RD_CYC must be at least 1"); end
      if (WHZ_CYC < 1)       begin : g_bad_z $error("WHZ_CYC must be at least 1"); end
      if (HOLD_CYC < 1)      begin : g_bad_h $error("HOLD_CYC must be at least 1"); end
      if (TURN_CYC < 1)      begin : g_bad_t $error("TURN_CYC must be at least 1"); end
   endgenerate

   logic          boot_done, req_fire, drive, capture;
   logic [DW-1:0] wdata_q;

   assign req_fire = req_valid && req_ready;

   sram_boot_timer #(.BOOT_CYC(BOOT_CYC)) u_boot (
      .clk  (clk),
      .rst_n(rst_n),
      .done (boot_done)
   );

   sram_phase_seq #(
      .RD_CYC   (RD_CYC),
      .WHZ_CYC  (WHZ_CYC),
      .PULSE_CYC(PULSE_CYC),
      .HOLD_CYC (HOLD_CYC),
      .TURN_CYC (TURN_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_done(boot_done),
      .req_fire (req_fire),
      .req_we   (req_we),
      .ready    (req_ready),
      .ce_n     (mem_ce_n),
      .oe_n     (mem_oe_n),
      .we_n     (mem_we_n),
      .drive    (drive),
      .capture  (capture)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         wdata_q   <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (req_fire) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
         end
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq;
      end
   end

   assign mem_dq = drive ? wdata_q : {DW{1'bz}};

   AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> (!mem_ce_n && mem_oe_n)); // R3
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> $stable(mem_addr)); // R5
   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (drive && $stable(wdata_q))); // R4
   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R6
endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
   localparam int unsigned AW = 19, DW = 8;
   localparam int unsigned BOOT = 10, RD = 2, WE = 2, SU = 1, HD = 1, WHZ = 1, TRN = 1, WC = 3;
   localparam int unsigned PULSE = 2; // max(WE, SU, WC-WHZ-HD)
   localparam int unsigned MDEP = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] mem_addr;
   wire  [DW-1:0] mem_dq;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [DW-1:0] ram [MDEP];
   logic [DW-1:0] shadow [MDEP];
   logic [DW-1:0] exp_q [$];
   logic [DW-1:0] cur_wdata = '0;

   always #10 clk = ~clk;

   sram_async_ctrl #(.AW(AW), .DW(DW), .BOOT_CYC(BOOT), .RD_CYC(RD), .WE_CYC(WE),
      .SETUP_CYC(SU), .HOLD_CYC(HD), .WHZ_CYC(WHZ), .TURN_CYC(TRN), .WC_CYC(WC))
   u_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq));

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // behavioural RAM: reads drive the bus, writes land when the overlap ends
   assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[mem_addr[5:0]] : {DW{1'bz}};

   logic          wr_on = 1'b0;
   int            wr_len = 0;
   logic [5:0]    wr_a = '0;
   logic [DW-1:0] wr_d = '0;
   logic p_ce = 1'b1, p_oe = 1'b1, p_we = 1'b1, wrote = 1'b0;
   int oe_run = 0, ce_hi = 0, pre_run = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (!mem_ce_n && !mem_we_n) begin
            wr_on = 1'b1; wr_len++; wr_a = mem_addr[5:0]; wr_d = mem_dq;
            check(mem_oe_n, "R5 oe high during write", mem_oe_n, 1);
         end else if (wr_on) begin
            ram[wr_a] = wr_d;
            check(wr_len == PULSE, "R4 write pulse length", wr_len, PULSE);
            check(mem_dq == cur_wdata, "R4 data held after we rises", mem_dq, cur_wdata);
            wr_on = 1'b0; wr_len = 0; wrote = 1'b1;
         end
         if (!mem_we_n && mem_ce_n) check(1'b0, "R5 ce low during write", 1, 0);
         if (!mem_ce_n && p_ce) pre_run = 0;
         if (!mem_ce_n && mem_we_n && mem_oe_n) pre_run++;
         if (!mem_we_n && p_we) check(pre_run == WHZ, "R4 release before pulse", pre_run, WHZ);
         if (!mem_oe_n) begin
            oe_run++;
            if (!mem_ce_n)
               check(mem_dq == ram[mem_addr[5:0]], "R3 bus untouched during read",
                     mem_dq, ram[mem_addr[5:0]]);
         end else if (!p_oe) begin
            check(oe_run == RD, "R6 read window length", oe_run, RD);
            oe_run = 0;
         end
         if (mem_ce_n) ce_hi++;
         else if (p_ce) begin
            if (wrote) check(ce_hi >= TRN + 1, "R7 turnaround", ce_hi, TRN + 1);
            wrote = 1'b0; ce_hi = 0;
         end
         if (rsp_valid) begin
            if (exp_q.size() == 0) check(1'b0, "R6 unexpected response", rsp_rdata, -1);
            else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               check(rsp_rdata == e, "R9 read data", rsp_rdata, e);
            end
         end
      end
      p_ce = mem_ce_n; p_oe = mem_oe_n; p_we = mem_we_n;
   end

   task automatic do_req(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_we = we; req_addr = a; req_wdata = d; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      if (we) begin shadow[a[5:0]] = d; cur_wdata = d; end
      else exp_q.push_back(shadow[a[5:0]]);
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready, "R8 busy after accept", req_ready, 0);
   endtask

   initial begin
      for (int i = 0; i < MDEP; i++) begin
         ram[i] = DW'(i) ^ 8'h3C; shadow[i] = DW'(i) ^ 8'h3C;
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 7);
      check(!rsp_valid, "R1 rsp_valid low", rsp_valid, 0);
      check(!req_ready, "R1 ready low", req_ready, 0);
      rst_n = 1'b1;
      repeat (BOOT) @(negedge clk);
      check(!req_ready, "R2 ready low at boot limit", req_ready, 0);
      @(negedge clk);
      check(req_ready, "R2 ready after boot", req_ready, 1);
      req_valid = 1'b0; req_we = 1'b1; req_addr = 19'h5;
      repeat (5) begin
         @(negedge clk);
         check(mem_ce_n && req_ready, "R10 idle without valid", {mem_ce_n, req_ready}, 3);
      end
      do_req(1'b0, 19'h07, '0);           // unwritten location
      do_req(1'b1, 19'h00, 8'hA5);
      do_req(1'b1, 19'h3F, 8'h5A);
      do_req(1'b0, 19'h00, '0);
      do_req(1'b0, 19'h3F, '0);
      do_req(1'b1, 19'h12, 8'hFF);
      do_req(1'b0, 19'h12, '0);           // read straight after write
      do_req(1'b1, 19'h12, 8'h00);        // overwrite
      do_req(1'b0, 19'h12, '0);
      do_req(1'b0, 19'h12, '0);           // back-to-back reads
      do_req(1'b1, 19'h40021, 8'h81);     // high address bits set
      do_req(1'b1, 19'h40022, 8'h7E);     // back-to-back writes
      do_req(1'b0, 19'h40021, '0);
      do_req(1'b0, 19'h40022, '0);
      for (int k = 0; k < 8; k++) do_req(1'b1, 19'(k * 7), 8'(k * 29 + 3));
      for (int k = 7; k >= 0; k--) do_req(1'b0, 19'(k * 7), '0);
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule